// File: doc/BRIEF.md
# Strobe-qualified host bus slave with region steering

This block sits between a host bus with memory-style timing and the buffer and register logic of a peripheral. The host drives a 16-bit byte offset, 32-bit write data and three active-low strobes: chip select, write enable and output enable. The slave counts how many consecutive clock edges a strobe stays valid. When that count reaches the minimum width, the access is accepted and the slave issues one single-cycle request to the region that the offset falls in. The regions are a receive area, a transmit area and a register bank.

After an accepted access, the slave ignores the strobes until it has sampled both enables high at least once. This forces a gap between accesses, and chip select may stay low during the gap. Read data is taken from the selected region in the same cycle that the read is accepted, and it is then held at the port. Region read data is expected to be a combinational function of the registered request address. A mode pin stretches the minimum width by a fixed number of extra cycles for hosts whose strobes are not tied to this clock.

Top module: `hbus_slave`

## Requirements
- R1: A write is accepted when cs_n and we_n are both sampled low on N consecutive rising edges. N is 3 when slow_mode is 0. After the Nth edge, the write request of the decoded region is high for exactly one cycle. At that point req_addr equals addr and req_wdata equals wdata as sampled at that edge.
- R2: A write whose strobes are sampled low on fewer than N consecutive edges produces no request of any region.
- R3: After an accepted access, no further access is accepted until some edge samples cs_n high, or samples we_n and oe_n both high. A strobe held low for much longer than N edges yields exactly one request. Switching directly from write to read without such an edge yields no read request.
- R4: A read needs cs_n and oe_n low with we_n high on N consecutive edges. At the Nth edge, the region's read request is pulsed for one cycle and rdata takes the region read data that belongs to req_addr. req_addr follows addr on every edge at which cs_n is low.
- R5: Offsets below 8000h select the receive region. Offsets 8000h to FBFFh select the transmit region. Offsets FC00h to FCFFh select the register bank.
- R6: Offsets FD00h to FFFFh select no region. An accepted access there raises no request, and an accepted read there sets rdata to zero.
- R7: rdata keeps its value until the next accepted read. Short reads and all writes leave it unchanged.
- R8: With slow_mode at 1, N becomes 6 (3 + 3) for both reads and writes. All other rules are unchanged.
- R9: While rst is high, and after its release, all request outputs are 0 and rdata, req_addr and req_wdata are zero until an access changes them.
- R10: cs_n may stay low between two accesses. A second write is accepted after we_n has been high on at least one edge, even though cs_n never rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_mode | input | 1 | 1 adds the extra qualification cycles |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Byte offset within the 64 KB window |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data returned to host, registered |
| rx_rdata | input | 32 | Receive region read data for req_addr |
| tx_rdata | input | 32 | Transmit region read data for req_addr |
| reg_rdata | input | 32 | Register bank read data for req_addr |
| req_addr | output | 16 | Registered request offset |
| req_wdata | output | 32 | Registered write data of the accepted write |
| rx_wr | output | 1 | Receive region write request pulse |
| rx_rd | output | 1 | Receive region read request pulse |
| tx_wr | output | 1 | Transmit region write request pulse |
| tx_rd | output | 1 | Transmit region read request pulse |
| reg_wr | output | 1 | Register bank write request pulse |
| reg_rd | output | 1 | Register bank read request pulse |

## Verification
The bench builds the block with its default parameters: a 3-cycle base width, 3 extra slow cycles and the 64 KB map with boundaries at 8000h, FC00h and FCFFh. It runs both values of slow_mode. These small widths let it sweep every strobe width just below, at and above N, in both modes and for both directions. The address of each sweep point sits on both sides of every region boundary. Expected region, pulse edge and read data come from arithmetic on the offset. Held strobes, a write switching to a read, and back-to-back accesses under a continuously low chip select exercise the access gap.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    RG_RX   = 2'd0,
    RG_TX   = 2'd1,
    RG_REG  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_WR   = 2'd1,
    K_RD   = 2'd2
  } kind_e;
endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TX_BASE  = 'h8000,
  parameter int REG_BASE = 'hFC00,
  parameter int REG_LAST = 'hFCFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] TXB = ADDR_W'(TX_BASE);
  localparam logic [ADDR_W-1:0] RGB = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] RGL = ADDR_W'(REG_LAST);

  always_comb begin
    if (addr < TXB)       region = RG_RX;
    else if (addr < RGB)  region = RG_TX;
    else if (addr <= RGL) region = RG_REG;
    else                  region = RG_NONE;
  end
endmodule

// File: rtl/hbus_qual.sv
module hbus_qual
  import hbus_pkg::*;
#(
  parameter int BASE_CYC = 3,
  parameter int SLOW_CYC = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  slow,
  input  kind_e kind,
  output logic  fire
);
  localparam int MAXC  = BASE_CYC + SLOW_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt, cnt_eff, need;
  kind_e prev;
  logic  armed;

  // consecutive-edge count restarts whenever the access kind changes
  always_comb begin
    need    = slow ? CNT_W'(MAXC) : CNT_W'(BASE_CYC);
    cnt_eff = (kind != prev) ? '0 : cnt;
    fire    = armed && (kind != K_IDLE) && (cnt_eff == need - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      prev  <= K_IDLE;
      armed <= 1'b1;
    end else begin
      prev <= kind;
      if (kind == K_IDLE) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else begin
        cnt <= (cnt_eff < need) ? cnt_eff + CNT_W'(1) : cnt_eff;
        if (fire) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int BASE_CYC = 3,
  parameter int SLOW_CYC = 3,
  parameter int TX_BASE  = 'h8000,
  parameter int REG_BASE = 'hFC00,
  parameter int REG_LAST = 'hFCFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_mode,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rx_rdata,
  input  logic [DATA_W-1:0] tx_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              rx_wr,
  output logic              rx_rd,
  output logic              tx_wr,
  output logic              tx_rd,
  output logic              reg_wr,
  output logic              reg_rd
);
  kind_e   kind;
  region_e region;
  logic    fire;

  always_comb begin
    if (cs_n)       kind = K_IDLE;
    else if (!we_n) kind = K_WR;
    else if (!oe_n) kind = K_RD;
    else            kind = K_IDLE;
  end

  hbus_decode #(
    .ADDR_W(ADDR_W), .TX_BASE(TX_BASE), .REG_BASE(REG_BASE), .REG_LAST(REG_LAST)
  ) u_dec (
    .addr(addr), .region(region)
  );

  hbus_qual #(
    .BASE_CYC(BASE_CYC), .SLOW_CYC(SLOW_CYC)
  ) u_qual (
    .clk(clk), .rst(rst), .slow(slow_mode), .kind(kind), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      rx_wr     <= 1'b0;
      rx_rd     <= 1'b0;
      tx_wr     <= 1'b0;
      tx_rd     <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      rx_wr  <= 1'b0;
      rx_rd  <= 1'b0;
      tx_wr  <= 1'b0;
      tx_rd  <= 1'b0;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (!cs_n) req_addr <= addr;
      if (fire && kind == K_WR) begin
        req_wdata <= wdata;
        case (region)
          RG_RX:   rx_wr  <= 1'b1;
          RG_TX:   tx_wr  <= 1'b1;
          RG_REG:  reg_wr <= 1'b1;
          RG_NONE: ;
        endcase
      end
      if (fire && kind == K_RD) begin
        case (region)
          RG_RX:   begin rx_rd  <= 1'b1; rdata <= rx_rdata;  end
          RG_TX:   begin tx_rd  <= 1'b1; rdata <= tx_rdata;  end
          RG_REG:  begin reg_rd <= 1'b1; rdata <= reg_rdata; end
          RG_NONE: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int TX_BASE  = 'h8000,
  parameter int REG_BASE = 'hFC00,
  parameter int REG_LAST = 'hFCFF
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] rx_rdata,
  input logic              rx_wr,
  input logic              rx_rd,
  input logic              tx_wr,
  input logic              tx_rd,
  input logic              reg_wr,
  input logic              reg_rd
);
  localparam logic [ADDR_W-1:0] TXB = ADDR_W'(TX_BASE);
  localparam logic [ADDR_W-1:0] RGB = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] RGL = ADDR_W'(REG_LAST);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic any_wr, any_rd;
  assign any_wr = rx_wr | tx_wr | reg_wr;
  assign any_rd = rx_rd | tx_rd | reg_rd;

  assert_one_request_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_wr, rx_rd, tx_wr, tx_rd, reg_wr, reg_rd}));

  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
    (any_wr | any_rd) |=> !(any_wr | any_rd));

  assert_write_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && any_wr) |-> $past(!cs_n && !we_n));

  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && any_rd) |-> $past(!cs_n && !oe_n && we_n));

  assert_rx_read_data_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rx_rd) |-> (rdata == $past(rx_rdata)));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !any_rd) |-> ($stable(rdata) || rdata == '0));

  assert_rx_range_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_wr || rx_rd) |-> (req_addr < TXB));

  assert_reg_range_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |-> (req_addr >= RGB && req_addr <= RGL));

  assert_tx_range_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_wr || tx_rd) |-> (req_addr >= TXB && req_addr < RGB));
endmodule

bind hbus_slave hbus_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .TX_BASE(TX_BASE), .REG_BASE(REG_BASE), .REG_LAST(REG_LAST)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .req_addr(req_addr), .rdata(rdata), .rx_rdata(rx_rdata),
  .rx_wr(rx_wr), .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_rd(tx_rd),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/sim_hbus_slave.sv
`timescale 1ns/1ps
module sim_hbus_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_mode = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rx_rdata, tx_rdata, reg_rdata, req_wdata;
  logic [15:0] req_addr;
  logic        rx_wr, rx_rd, tx_wr, tx_rd, reg_wr, reg_rd;

  int compared = 0;
  int mismatched = 0;
  int edge_no = 0;
  int start_edge = 0;
  int pw[4];
  int pr[4];
  int pedge;
  logic [15:0] paddr;
  logic [31:0] pdata;
  logic [31:0] exp_rdata = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] model(input int r, input logic [15:0] a);
    return {8'hA0 | 8'(r), 8'h5C, a};
  endfunction

  function automatic int region_of(input logic [15:0] a);
    if (a < 16'h8000) return 0;
    if (a < 16'hFC00) return 1;
    if (a <= 16'hFCFF) return 2;
    return 3;
  endfunction

  assign rx_rdata  = model(0, req_addr);
  assign tx_rdata  = model(1, req_addr);
  assign reg_rdata = model(2, req_addr);

  hbus_slave u0 (
    .clk(clk), .rst(rst), .slow_mode(slow_mode), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_rdata(rx_rdata), .tx_rdata(tx_rdata),
    .reg_rdata(reg_rdata), .req_addr(req_addr), .req_wdata(req_wdata),
    .rx_wr(rx_wr), .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_rd(tx_rd),
    .reg_wr(reg_wr), .reg_rd(reg_rd)
  );

  always @(posedge clk) edge_no <= edge_no + 1;

  always @(negedge clk) begin
    if (rx_wr || tx_wr || reg_wr || rx_rd || tx_rd || reg_rd) begin
      if (rx_wr)  pw[0]++;
      if (tx_wr)  pw[1]++;
      if (reg_wr) pw[2]++;
      if (rx_rd)  pr[0]++;
      if (tx_rd)  pr[1]++;
      if (reg_rd) pr[2]++;
      if (pedge < 0) begin
        pedge = edge_no - start_edge;
        paddr = req_addr;
        pdata = req_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int i = 0; i < 4; i++) begin pw[i] = 0; pr[i] = 0; end
    pedge = -1;
  endtask

  function automatic int total();
    int s = 0;
    for (int i = 0; i < 4; i++) s += pw[i] + pr[i];
    return s;
  endfunction

  task automatic acc(input bit wr, input logic [15:0] a, input logic [31:0] d,
                     input int width, input int gap, input bit keep_cs);
    @(negedge clk);
    clear_mon();
    cs_n = 1'b0; addr = a; wdata = d;
    if (wr) we_n = 1'b0; else oe_n = 1'b0;
    start_edge = edge_no;
    repeat (width) @(negedge clk);
    we_n = 1'b1; oe_n = 1'b1;
    if (!keep_cs) cs_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic check_acc(input bit wr, input logic [15:0] a, input logic [31:0] d,
                           input int width, input int n);
    int r = region_of(a);
    bit ok = (width >= n) && (r != 3);
    string tw = (n == 6) ? "R8" : ((width < n) ? "R2" : ((r == 3) ? "R6" : (wr ? "R1" : "R4")));
    chk(total() == (ok ? 1 : 0), tw, 32'(total()), ok ? 1 : 0);
    if (ok) begin
      chk(wr ? pw[r] == 1 : pr[r] == 1, "R5", 32'(r), 32'(r));
      chk(pedge == n, tw, 32'(pedge), 32'(n));
      chk(paddr == a, wr ? "R1" : "R4", 32'(paddr), 32'(a));
      if (wr) chk(pdata == d, "R1", pdata, d);
    end
    if (!wr && width >= n) exp_rdata = (r == 3) ? 32'h0 : model(r, a);
    chk(rdata == exp_rdata, wr ? "R7" : ((r == 3) ? "R6" : "R7"), rdata, exp_rdata);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] pts[8];
    int n;
    pts[0] = 16'h0000; pts[1] = 16'h7FFF; pts[2] = 16'h8000; pts[3] = 16'hFBFF;
    pts[4] = 16'hFC00; pts[5] = 16'hFCFF; pts[6] = 16'hFD00; pts[7] = 16'hFFFF;
    clear_mon();
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(rdata == 0, "R9", rdata, 0);
    chk(req_addr == 0 && req_wdata == 0, "R9", {req_addr, 16'h0}, 0);
    chk({rx_wr, rx_rd, tx_wr, tx_rd, reg_wr, reg_rd} == 0, "R9",
        32'({rx_wr, rx_rd, tx_wr, tx_rd, reg_wr, reg_rd}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(rdata == 0 && req_addr == 0, "R9", rdata, 0);

    for (int s = 0; s < 2; s++) begin
      slow_mode = 1'(s);
      n = (s == 1) ? 6 : 3;
      for (int p = 0; p < 8; p++) begin
        for (int w = n - 1; w <= n + 2; w++) begin
          for (int dir = 0; dir < 2; dir++) begin
            logic [31:0] d = {pts[p] ^ 16'h3C3C, 16'(w * 16 + s)};
            acc(dir == 0, pts[p], d, w, 2, 0);
            check_acc(dir == 0, pts[p], d, w, n);
          end
        end
      end
    end

    slow_mode = 1'b0;
    // R3: long hold gives one request
    acc(1'b1, 16'h8004, 32'hDEAD0001, 9, 2, 0);
    chk(pw[1] == 1 && total() == 1, "R3", 32'(total()), 1);

    // R3: write switching to read without an idle edge
    @(negedge clk);
    clear_mon();
    cs_n = 1'b0; we_n = 1'b0; addr = 16'h0040; wdata = 32'h12345678;
    repeat (3) @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    oe_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pw[0] == 1 && pr[0] == 0, "R3", 32'(pr[0]), 0);
    chk(rdata == exp_rdata, "R3", rdata, exp_rdata);

    // R10: chip select stays low between two writes
    acc(1'b1, 16'hFC10, 32'hCAFE0010, 3, 1, 1);
    chk(pw[2] == 1 && total() == 1, "R10", 32'(total()), 1);
    acc(1'b1, 16'hFC14, 32'hCAFE0014, 3, 2, 0);
    chk(pw[2] == 1 && total() == 1, "R10", 32'(total()), 1);
    chk(pdata == 32'hCAFE0014 && paddr == 16'hFC14, "R10", pdata, 32'hCAFE0014);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule